// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the pins of one GPIO bank and turns pin activity into latched interrupt status. Every pin has its own trigger selection, built from three parallel per-pin mask registers. The selection picks one of five conditions: falling edge, rising edge, any edge, low level or high level. The pin inputs are expected to be already synchronised and filtered. Edges are found by comparing each pin with a registered copy of its previous sample.

Software programs an enable mask and the three trigger masks through a simple word-wide register port. It reads the pending status from the same port and clears pending bits by writing ones to them. A single interrupt line is asserted while any pin has both its status bit and its enable bit set. Pin `n` of the bank sits at bit `n` of every register, so the position of a pin is the low five bits of its global GPIO number.

Top module: `gpio_irq_bank`

## Requirements
- R1: While reset is asserted, and directly after it, every register (enable, the three trigger masks, status) reads zero and `irq` is low. The previous-sample register also resets to zero, so a pin that is high in the first clock after reset counts as a rising edge.
- R2: The byte addresses are 0x00 enable, 0x04 trigger mask A, 0x08 trigger mask B, 0x0C trigger mask C and 0x10 status. The first four read back what was last written. Writes to any other address are ignored, and reads of any other address return zero.
- R3: When a pin's bits (C,B,A) are 0,0,0, a 1-to-0 change of the pin sets its status bit at the clock edge where the new value is first sampled.
- R4: When C=0, B=0 and A=1, a 0-to-1 change of the pin sets its status bit at the clock edge where the new value is first sampled.
- R5: When C=1 and B=0, either change of the pin sets its status bit, whatever A holds. In any edge mode, a pin whose sample equals its previous sample never sets status.
- R6: When B=1 the pin is level-sensitive and C has no effect: A=1 sets status on every clock while the pin is high, and A=0 does so while it is low. A clear written while the level persists is overridden in that same cycle.
- R7: A write to the status address clears exactly the status bits where the written word has a 1, and leaves the other bits as they are. When a pin's trigger fires in the same cycle as its clear, the set wins.
- R8: A pin can set its status bit only while its enable bit is 1. Clearing the enable bit does not clear a status bit that is already set.
- R9: `irq` equals the OR over all pins of (status AND enable). With IRQ_REGISTERED=0 it follows the registers in the same cycle; with IRQ_REGISTERED=1 it lags them by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Filtered pin levels of the bank |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte address of the combinational read |
| rd_data | output | DATA_W | Read data, zero-extended above NPINS |
| irq | output | 1 | Bank interrupt request |

## Verification
The bench targets the level-mode case where software clears a pin whose level is still active. A design that let the clear win would show a status bit that drops for one cycle and then returns. It drives pins that rise or fall with their enable bit low; a design without enable gating would latch those edges, and they would later appear as spurious interrupts. It checks that a mask with C set and B set acts as a level trigger, which catches a wrong priority between the mask bits. It also checks writes to unmapped addresses and zero-bit status writes, which a loose address decoder or a plain-write status register would turn into lost or corrupted state. Long random runs cover clears that arrive in the same cycle as new events, and toggling enables while status is pending.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Register selected by a byte address on the register port.
   typedef enum logic [2:0] {
      SEL_ENABLE = 3'd0,
      SEL_TRIG_A = 3'd1,
      SEL_TRIG_B = 3'd2,
      SEL_TRIG_C = 3'd3,
      SEL_STATUS = 3'd4,
      SEL_NONE   = 3'd7
   } reg_sel_e;

   // Trigger condition of one pin, decoded from its three mask bits.
   typedef enum logic [2:0] {
      TRIG_FALL = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_ANY  = 3'd2,
      TRIG_LOW  = 3'd3,
      TRIG_HIGH = 3'd4
   } trig_e;

   localparam int unsigned DEC_W = 12;

   function automatic reg_sel_e sel_of(input logic [DEC_W-1:0] byte_addr);
      case (byte_addr)
         12'h000: return SEL_ENABLE;
         12'h004: return SEL_TRIG_A;
         12'h008: return SEL_TRIG_B;
         12'h00C: return SEL_TRIG_C;
         12'h010: return SEL_STATUS;
         default: return SEL_NONE;
      endcase
   endfunction

   // Mask B dominates (level), then mask C (any edge), then mask A picks polarity.
   function automatic trig_e trig_of(input logic a, input logic b, input logic c);
      if (b)
         return a ? TRIG_HIGH : TRIG_LOW;
      else if (c)
         return TRIG_ANY;
      else
         return a ? TRIG_RISE : TRIG_FALL;
   endfunction

endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [NPINS-1:0]  status_i,
   output logic [DATA_W-1:0] rd_data,
   output logic [NPINS-1:0]  en_q,
   output logic [NPINS-1:0]  trig_a_q,
   output logic [NPINS-1:0]  trig_b_q,
   output logic [NPINS-1:0]  trig_c_q,
   output logic [NPINS-1:0]  clr_mask
);

   localparam int unsigned PAD_W = DATA_W - NPINS;

   reg_sel_e         wsel;
   reg_sel_e         rsel;
   logic [NPINS-1:0] wbits;
   logic [NPINS-1:0] rbits;

   assign wsel  = sel_of(DEC_W'(wr_addr));
   assign rsel  = sel_of(DEC_W'(rd_addr));
   assign wbits = wr_data[NPINS-1:0];

   // Status is write-one-to-clear: a write there only produces a clear mask.
   assign clr_mask = (wr_en && (wsel == SEL_STATUS)) ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         trig_a_q <= '0;
         trig_b_q <= '0;
         trig_c_q <= '0;
      end else if (wr_en) begin
         case (wsel)
            SEL_ENABLE: en_q     <= wbits;
            SEL_TRIG_A: trig_a_q <= wbits;
            SEL_TRIG_B: trig_b_q <= wbits;
            SEL_TRIG_C: trig_c_q <= wbits;
            default:    ;
         endcase
      end
   end

   always_comb begin
      case (rsel)
         SEL_ENABLE: rbits = en_q;
         SEL_TRIG_A: rbits = trig_a_q;
         SEL_TRIG_B: rbits = trig_b_q;
         SEL_TRIG_C: rbits = trig_c_q;
         SEL_STATUS: rbits = status_i;
         default:    rbits = '0;
      endcase
   end

   generate
      if (PAD_W == 0) begin : g_rd_full
         assign rd_data = rbits;
      end else begin : g_rd_pad
         assign rd_data = {{PAD_W{1'b0}}, rbits};
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic [NPINS-1:0] trig_a,
   input  logic [NPINS-1:0] trig_b,
   input  logic [NPINS-1:0] trig_c,
   output logic [NPINS-1:0] prev_q,
   output logic [NPINS-1:0] hit
);

   // Previous sample of every pin; edges are found against it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= '0;
      else
         prev_q <= pin_in;
   end

   generate
      for (genvar p = 0; p < NPINS; p++) begin : g_pin
         trig_e mode;
         logic  rose;
         logic  fell;

         assign mode = trig_of(trig_a[p], trig_b[p], trig_c[p]);
         assign rose = pin_in[p] & ~prev_q[p];
         assign fell = ~pin_in[p] & prev_q[p];

         always_comb begin
            case (mode)
               TRIG_FALL: hit[p] = fell;
               TRIG_RISE: hit[p] = rose;
               TRIG_ANY:  hit[p] = rose | fell;
               TRIG_LOW:  hit[p] = ~pin_in[p];
               TRIG_HIGH: hit[p] = pin_in[p];
               default:   hit[p] = 1'b0;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
   parameter int unsigned NPINS          = 32,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] hit,
   input  logic [NPINS-1:0] en,
   input  logic [NPINS-1:0] clr_mask,
   output logic [NPINS-1:0] status_q,
   output logic             irq
);

   logic [NPINS-1:0] status_d;
   logic             pending;

   // Set has priority over a simultaneous clear of the same bit.
   assign status_d = (status_q & ~clr_mask) | (hit & en);
   assign pending  = |(status_q & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status_q <= '0;
      else
         status_q <= status_d;
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= pending;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = pending;
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
   parameter int unsigned NPINS          = 32,
   parameter int unsigned ADDR_W         = 5,
   parameter int unsigned DATA_W         = 32,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);

   generate
      if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
         $error("gpio_irq_bank: NPINS must lie in 1..DATA_W");
      end
      if (ADDR_W < 5 || ADDR_W > 12) begin : g_bad_addr
         $error("gpio_irq_bank: ADDR_W must lie in 5..12");
      end
   endgenerate

   logic [NPINS-1:0] en_q;
   logic [NPINS-1:0] trig_a_q;
   logic [NPINS-1:0] trig_b_q;
   logic [NPINS-1:0] trig_c_q;
   logic [NPINS-1:0] clr_mask;
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] hit;
   logic [NPINS-1:0] status_q;

   gpio_irq_regs #(
      .NPINS (NPINS),
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .status_i(status_q),
      .rd_data (rd_data),
      .en_q    (en_q),
      .trig_a_q(trig_a_q),
      .trig_b_q(trig_b_q),
      .trig_c_q(trig_c_q),
      .clr_mask(clr_mask)
   );

   gpio_irq_detect #(
      .NPINS(NPINS)
   ) u_detect (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_in(pin_in),
      .trig_a(trig_a_q),
      .trig_b(trig_b_q),
      .trig_c(trig_c_q),
      .prev_q(prev_q),
      .hit   (hit)
   );

   gpio_irq_status #(
      .NPINS         (NPINS),
      .IRQ_REGISTERED(IRQ_REGISTERED)
   ) u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (hit),
      .en      (en_q),
      .clr_mask(clr_mask),
      .status_q(status_q),
      .irq     (irq)
   );

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int unsigned NPINS          = 32,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] pin_in,
   input logic [NPINS-1:0] prev_q,
   input logic [NPINS-1:0] en_q,
   input logic [NPINS-1:0] trig_a_q,
   input logic [NPINS-1:0] trig_b_q,
   input logic [NPINS-1:0] clr_mask,
   input logic [NPINS-1:0] status_q,
   input logic             irq
);

   logic [NPINS-1:0] level_active;
   logic [NPINS-1:0] edge_seen;

   assign level_active = en_q & trig_b_q & ~(trig_a_q ^ pin_in);
   assign edge_seen    = pin_in ^ prev_q;

   // R1: reset holds status and the interrupt line low
   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (status_q == '0 && !irq));

   // R8: a status bit only rises on a pin that was enabled
   assert_set_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(en_q)) == '0));

   // R7: a status bit only falls where a one was written to status
   assert_clear_only_by_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((~status_q & $past(status_q) & ~$past(clr_mask)) == '0));

   // R5: in edge modes a new status bit needs a changed sample
   assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(trig_b_q) & ~$past(edge_seen)) == '0));

   // R6: an active enabled level always leaves the status bit set
   assert_level_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(level_active) & ~status_q) == '0));

   generate
      if (IRQ_REGISTERED) begin : g_chk_reg
         // R9: registered interrupt lags the pending set by one clock
         assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(|(status_q & en_q)));
      end else begin : g_chk_comb
         // R9: combinational interrupt matches the pending set
         assert_irq_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(status_q & en_q));
      end
   endgenerate

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
   .NPINS         (NPINS),
   .IRQ_REGISTERED(IRQ_REGISTERED)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pin_in  (pin_in),
   .prev_q  (prev_q),
   .en_q    (en_q),
   .trig_a_q(trig_a_q),
   .trig_b_q(trig_b_q),
   .clr_mask(clr_mask),
   .status_q(status_q),
   .irq     (irq)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pin_in = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // bench model of the register state
   logic [31:0] m_en = '0, m_a = '0, m_b = '0, m_c = '0, m_st = '0, m_prev = '0;

   always #2 clk = ~clk;

   gpio_irq_bank uut (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_in),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .rd_addr(rd_addr),
      .rd_data(rd_data),
      .irq    (irq)
   );

   // trigger rule per pin, from the bit codes in R3..R6
   function automatic logic [31:0] trig_hits(input logic [31:0] a, input logic [31:0] b,
                                             input logic [31:0] c, input logic [31:0] pin,
                                             input logic [31:0] prev);
      logic [31:0] h;
      for (int i = 0; i < 32; i++) begin
         if (b[i])      h[i] = a[i] ? pin[i] : ~pin[i];
         else if (c[i]) h[i] = pin[i] != prev[i];
         else if (a[i]) h[i] = pin[i] & ~prev[i];
         else           h[i] = ~pin[i] & prev[i];
      end
      return h;
   endfunction

   function automatic logic [31:0] model_read(input logic [4:0] addr);
      case (addr)
         5'h00: return m_en;
         5'h04: return m_a;
         5'h08: return m_b;
         5'h0C: return m_c;
         5'h10: return m_st;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: predict, advance, compare rd_data and irq against the model
   task automatic tick(input string tag);
      logic [31:0] clr, nst, nen, na, nb, nc;
      clr = (wr_en && wr_addr == 5'h10) ? wr_data : 32'h0;
      nst = (m_st & ~clr) | (trig_hits(m_a, m_b, m_c, pin_in, m_prev) & m_en);
      nen = m_en; na = m_a; nb = m_b; nc = m_c;
      if (wr_en) begin
         case (wr_addr)
            5'h00: nen = wr_data;
            5'h04: na  = wr_data;
            5'h08: nb  = wr_data;
            5'h0C: nc  = wr_data;
            default: ;
         endcase
      end
      @(posedge clk);
      #1;
      m_prev = pin_in;
      m_st = nst; m_en = nen; m_a = na; m_b = nb; m_c = nc;
      wr_en = 1'b0;
      #0.5;
      chk(rd_data == model_read(rd_addr), tag, rd_data, model_read(rd_addr), "rd_data");
      chk(irq == |(m_st & m_en), tag, {31'h0, irq}, {31'h0, |(m_st & m_en)}, "irq");
   endtask

   task automatic wr(input logic [4:0] addr, input logic [31:0] data, input string tag);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      tick(tag);
   endtask

   task automatic expect_status(input logic [31:0] exp, input string tag);
      rd_addr = 5'h10;
      #0.1;
      chk(rd_data == exp, tag, rd_data, exp, "status");
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // R1: reset state
      for (int a = 0; a <= 16; a += 4) begin
         rd_addr = 5'(a);
         #0.1;
         chk(rd_data == 32'h0, "R1", rd_data, 32'h0, "reset read");
      end
      chk(irq == 1'b0, "R1", {31'h0, irq}, 32'h0, "reset irq");
      #1 rst_n = 1'b1;
      rd_addr = 5'h10;
      tick("R1");

      // R2: read-back and unmapped address
      wr(5'h04, 32'h1234_5678, "R2");
      rd_addr = 5'h04; #0.1;
      chk(rd_data == 32'h1234_5678, "R2", rd_data, 32'h1234_5678, "mask A readback");
      wr(5'h14, 32'hFFFF_FFFF, "R2");
      rd_addr = 5'h14; #0.1;
      chk(rd_data == 32'h0, "R2", rd_data, 32'h0, "unmapped read");
      rd_addr = 5'h04; #0.1;
      chk(rd_data == 32'h1234_5678, "R2", rd_data, 32'h1234_5678, "unmapped write ignored");
      wr(5'h04, 32'h0, "R2");
      rd_addr = 5'h10;

      // R3: falling edge on pin 0
      wr(5'h00, 32'h1, "R3");
      pin_in[0] = 1'b1; tick("R3");
      expect_status(32'h0, "R3");
      pin_in[0] = 1'b0; tick("R3");
      expect_status(32'h1, "R3");
      chk(irq == 1'b1, "R9", {31'h0, irq}, 32'h1, "irq on pending");

      // R7: zero write keeps, one write clears
      wr(5'h10, 32'hFFFF_FFFE, "R7");
      expect_status(32'h1, "R7");
      wr(5'h10, 32'h1, "R7");
      expect_status(32'h0, "R7");

      // R4: rising edge on pin 1
      wr(5'h00, 32'h3, "R4");
      wr(5'h04, 32'h2, "R4");
      pin_in[1] = 1'b1; tick("R4");
      expect_status(32'h2, "R4");
      wr(5'h10, 32'h2, "R4");
      pin_in[1] = 1'b0; tick("R4");
      expect_status(32'h0, "R4");

      // R5: any edge on pin 2 with mask A clear
      wr(5'h00, 32'h7, "R5");
      wr(5'h0C, 32'h4, "R5");
      pin_in[2] = 1'b1; tick("R5");
      expect_status(32'h4, "R5");
      wr(5'h10, 32'h4, "R5");
      expect_status(32'h0, "R5");
      pin_in[2] = 1'b0; tick("R5");
      expect_status(32'h4, "R5");
      wr(5'h10, 32'h4, "R5");

      // R6: level high on pin 3 with mask C also set, clear while held
      wr(5'h0C, 32'h0C, "R6");
      wr(5'h04, 32'h0A, "R6");
      wr(5'h08, 32'h08, "R6");
      wr(5'h00, 32'h0F, "R6");
      pin_in[3] = 1'b1; tick("R6");
      expect_status(32'h8, "R6");
      wr(5'h10, 32'h8, "R6");
      expect_status(32'h8, "R6");
      pin_in[3] = 1'b0; tick("R6");
      wr(5'h10, 32'h8, "R6");
      expect_status(32'h0, "R6");

      // R8: disabled pin 5 rising is ignored; enable drop keeps status
      wr(5'h04, 32'h2A, "R8");
      pin_in[5] = 1'b1; tick("R8");
      tick("R8");
      expect_status(32'h0, "R8");
      pin_in[3] = 1'b1; tick("R8");
      expect_status(32'h8, "R8");
      wr(5'h00, 32'h0, "R8");
      pin_in[3] = 1'b0; tick("R8");
      expect_status(32'h8, "R8");
      chk(irq == 1'b0, "R9", {31'h0, irq}, 32'h0, "masked pending");
      wr(5'h10, 32'hFFFF_FFFF, "R7");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         pin_in = pin_in ^ ($urandom & $urandom & $urandom);
         r = $urandom;
         if (r[1:0] == 2'b00) begin
            wr_en = 1'b1;
            case (r[6:4])
               3'd0: wr_addr = 5'h00;
               3'd1: wr_addr = 5'h04;
               3'd2: wr_addr = 5'h08;
               3'd3: wr_addr = 5'h0C;
               3'd4, 3'd5: wr_addr = 5'h10;
               3'd6: wr_addr = 5'h14;
               default: wr_addr = 5'h1C;
            endcase
            wr_data = $urandom;
         end
         rd_addr = r[8] ? 5'h10 : {r[12:10], 2'b00};
         tick("R7");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule